// File: doc/BRIEF.md
# Interrupt Pending Status Register

This block gathers interrupt requests from on-chip peripherals and from external interrupt pins into one 32-bit status word that software reads through a single-address register port. Peripheral request lines are copied into the word as they are, so their bits clear only when the peripheral withdraws its request. Four external pins, which are active low, can each be set to edge capture or level following. A fifth external pin, also active low, always captures on its falling edge. Captured bits are cleared by writing a 1 to their positions.

Every external pin goes through a two-register synchronizer before its edge is detected. The register port has a read strobe, a write strobe and a write data bus. Read data is registered and changes only in cycles where the read strobe is high. A per-pin mode vector selects the behaviour of each programmable pin. The block does no masking, no prioritising and no vector generation. Those are done downstream.

Top module: `irq_status_reg`

## Requirements
- R1: After a synchronous reset, a read returns 0x00000000.
- R2: Status bits 15..0 follow `live_req[15:0]`, and status bits 22..20 follow `live_req[18:16]`. They set and clear with their sources, and writing 1 to these positions has no effect.
- R3: Status bits 31..24 always read as zero.
- R4: Status bit 23 is set by a falling edge on `fixed_pin_n`. It is set on the third rising clock edge after the pin goes low, and it stays set after the pin returns high.
- R5: Status bit 23 is cleared only by a write with `bus_wdata[23]`=1. A write with a 0 in that position leaves it set.
- R6: When `edge_mode[i]`=1, status bit 16+i is set by a falling edge on `prog_pin_n[i]`. The timing is the same as in R4. The bit holds until a write with `bus_wdata[16+i]`=1.
- R7: When `edge_mode[i]`=0, status bit 16+i is 1 while `prog_pin_n[i]` is low (after synchronization) and 0 while it is high. Writing 1 to that bit has no effect.
- R8: If a captured falling edge sets a bit on the same clock edge as a write-1 clear of that bit, the bit stays set.
- R9: Changing a pin from edge mode to level mode while its pin is high discards the latched state, so the bit reads 0.
- R10: A rising edge on an edge-mode pin does not set its bit.
- R11: `bus_rdata` is loaded from the status word on the clock edge where `bus_rd`=1. It holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| live_req | input | 19 | Peripheral request lines: [15:0] map to bits 15..0, [18:16] map to bits 22..20 |
| prog_pin_n | input | 4 | Programmable external pins, active low, map to bits 19..16 |
| fixed_pin_n | input | 1 | Always edge-captured external pin, active low, maps to bit 23 |
| edge_mode | input | 4 | Per-pin mode for prog_pin_n: 1 = edge capture, 0 = level following |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (write-one-to-clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach is a new falling edge that lands on the exact clock edge of a write-1 clear of the same bit, when that bit is already set from an earlier edge. The stimulus first latches the bit and returns the pin high. It then drives the pin low at a falling clock edge, waits two rising edges for the synchronizer, and raises the write strobe so that the clear arrives on the third rising edge, together with the detected edge. A design that gives the clear priority over the edge reads back 0 in this case.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int REG_W        = 32;
  localparam int LIVE_LO_W    = 16;
  localparam int LIVE_HI_W    = 3;
  localparam int LIVE_N       = LIVE_LO_W + LIVE_HI_W;
  localparam int PROG_N       = 4;
  localparam int PROG_BASE    = 16;
  localparam int LIVE_HI_BASE = 20;
  localparam int FIXED_BIT    = 23;
  localparam int USED_TOP     = FIXED_BIT;
  localparam int SYNC_STAGES  = 2;

  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stage_q;

  // Idle level of active-low pins is high, so reset to ones.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '1;
          else     stage_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '1;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/edge_capture_cell.sv
module edge_capture_cell #(
  parameter bit FIXED_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic level_mode,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic fall;
  logic lvl_eff;

  generate
    if (FIXED_EDGE) begin : g_fixed
      assign lvl_eff = 1'b0;
    end else begin : g_prog
      assign lvl_eff = level_mode;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_s;
  end

  assign fall = prev_q & ~pin_s;

  // A new edge outranks a same-cycle clear; level mode drops latched state.
  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (lvl_eff) pend <= ~pin_s;
    else              pend <= (pend & ~clr) | fall;
  end

  p_edge_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!lvl_eff && pend && !clr) |=> (pend || lvl_eff));

  p_edge_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (!lvl_eff && fall) |=> pend);

  p_level_follow_r7: assert property (@(posedge clk) disable iff (rst)
    lvl_eff |=> (pend == !$past(pin_s)));
endmodule

// File: rtl/live_status.sv
module live_status #(
  parameter int N = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] stat
);
  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= req;
  end

  p_live_copy_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat == $past(req)));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irqs_pkg::*;
#(
  parameter int N_LIVE = LIVE_N,
  parameter int N_PROG = PROG_N,
  parameter int N_SYNC = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_LIVE-1:0] live_req,
  input  logic [N_PROG-1:0] prog_pin_n,
  input  logic              fixed_pin_n,
  input  logic [N_PROG-1:0] edge_mode,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);
  localparam int N_PINS = N_PROG + 1;

  logic [N_LIVE-1:0] live_q;
  logic [N_PINS-1:0] pins_raw, pins_s;
  logic [N_PROG-1:0] prog_pend, prog_clr;
  logic              fixed_pend, fixed_clr;
  word_t             status_w;

  assign pins_raw = {fixed_pin_n, prog_pin_n};

  pin_sync #(.W(N_PINS), .STAGES(N_SYNC)) u_sync (
    .clk(clk), .rst(rst), .din(pins_raw), .dout(pins_s)
  );

  live_status #(.N(N_LIVE)) u_live (
    .clk(clk), .rst(rst), .req(live_req), .stat(live_q)
  );

  generate
    for (genvar i = 0; i < N_PROG; i++) begin : g_prog
      assign prog_clr[i] = bus_wr & bus_wdata[PROG_BASE+i];
      edge_capture_cell #(.FIXED_EDGE(1'b0)) u_cell (
        .clk(clk), .rst(rst), .pin_s(pins_s[i]),
        .level_mode(~edge_mode[i]), .clr(prog_clr[i]), .pend(prog_pend[i])
      );
    end
  endgenerate

  assign fixed_clr = bus_wr & bus_wdata[FIXED_BIT];

  edge_capture_cell #(.FIXED_EDGE(1'b1)) u_fixed (
    .clk(clk), .rst(rst), .pin_s(pins_s[N_PROG]),
    .level_mode(1'b0), .clr(fixed_clr), .pend(fixed_pend)
  );

  always_comb begin
    status_w = '0;
    status_w[LIVE_LO_W-1:0]                      = live_q[LIVE_LO_W-1:0];
    status_w[PROG_BASE +: N_PROG]                = prog_pend;
    status_w[LIVE_HI_BASE +: (N_LIVE-LIVE_LO_W)] = live_q[N_LIVE-1:LIVE_LO_W];
    status_w[FIXED_BIT]                          = fixed_pend;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= status_w;
  end

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[REG_W-1:USED_TOP+1] == '0);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  p_fixed_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (fixed_pend && !(bus_wr && bus_wdata[FIXED_BIT])) |=> fixed_pend);
endmodule

// File: tb/irq_status_reg_tb.sv
module irq_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] live_req = '0;
  logic [3:0]  prog_pin_n = '1;
  logic        fixed_pin_n = 1'b1;
  logic [3:0]  edge_mode = '1;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  irq_status_reg u_dut (
    .clk(clk), .rst(rst), .live_req(live_req), .prog_pin_n(prog_pin_n),
    .fixed_pin_n(fixed_pin_n), .edge_mode(edge_mode), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Monitor: compare read data one edge after a sampled read strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        item_t it;
        @(negedge clk);
        it = sb_q.pop_front();
        checks++;
        if ((bus_rdata & it.mask) !== (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s: actual=%08h expected=%08h mask=%08h",
                   it.tag, bus_rdata, it.exp, it.mask);
        end
      end
    end
  end

  task automatic rd_chk(input logic [31:0] exp, input logic [31:0] mask,
                        input string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.mask = mask; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic direct_chk(input logic [31:0] exp, input string tag);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, bus_rdata, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset state
    rd_chk(32'h0, '1, "R1 reset");

    // R2: live sources, two patterns and clearing
    @(negedge clk); live_req = 19'h5A5A5 & 19'h7FFFF;
    rd_chk({9'h0, live_req[18:16], 4'h0, live_req[15:0]}, '1, "R2 pattern A");
    @(negedge clk); live_req = 19'h2C3F0;
    rd_chk({9'h0, live_req[18:16], 4'h0, live_req[15:0]}, '1, "R2 pattern B");
    wr(32'hFFFF_FFFF);
    rd_chk({9'h0, live_req[18:16], 4'h0, live_req[15:0]}, '1, "R2 write1 no effect");
    @(negedge clk); live_req = '0;
    rd_chk(32'h0, '1, "R2 cleared by source");

    // R3: everything active, upper byte still zero
    @(negedge clk); live_req = '1; prog_pin_n = '0; fixed_pin_n = 1'b0;
    idle(5);
    rd_chk(32'h0, 32'hFF00_0000, "R3 upper byte");
    @(negedge clk); live_req = '0; prog_pin_n = '1; fixed_pin_n = 1'b1;
    idle(5);
    wr(32'h00FF_0000);
    rd_chk(32'h0, '1, "R3 cleanup state");

    // R4: fixed pin falling edge latched, holds after release
    @(negedge clk); fixed_pin_n = 1'b0;
    idle(4);
    rd_chk(32'h0080_0000, '1, "R4 fixed edge set");
    @(negedge clk); fixed_pin_n = 1'b1;
    idle(4);
    rd_chk(32'h0080_0000, '1, "R4 holds after release");
    // R5: write 0 keeps, write 1 clears
    wr(32'hFF7F_FFFF);
    rd_chk(32'h0080_0000, '1, "R5 write0 no effect");
    wr(32'h0080_0000);
    rd_chk(32'h0, '1, "R5 write1 clears");

    // R6: programmable edge capture on pin 1 (bit 17)
    @(negedge clk); prog_pin_n[1] = 1'b0;
    idle(4);
    rd_chk(32'h0002_0000, '1, "R6 edge set");
    // R10: rising edge does not set a fresh bit
    wr(32'h0002_0000);
    rd_chk(32'h0, '1, "R6 write1 clears");
    @(negedge clk); prog_pin_n[1] = 1'b1;
    idle(4);
    rd_chk(32'h0, '1, "R10 rising edge ignored");

    // R7: pin 2 level mode (bit 18)
    @(negedge clk); edge_mode[2] = 1'b0; prog_pin_n[2] = 1'b0;
    idle(4);
    rd_chk(32'h0004_0000, '1, "R7 level low pending");
    wr(32'h0004_0000);
    rd_chk(32'h0004_0000, '1, "R7 write1 no effect");
    @(negedge clk); prog_pin_n[2] = 1'b1;
    idle(4);
    rd_chk(32'h0, '1, "R7 level released");

    // R8: new edge coincides with clear on pin 3 (bit 19), already set
    @(negedge clk); prog_pin_n[3] = 1'b0;
    idle(4);
    @(negedge clk); prog_pin_n[3] = 1'b1;
    idle(4);
    rd_chk(32'h0008_0000, '1, "R8 precondition set");
    @(negedge clk); prog_pin_n[3] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = 32'h0008_0000;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    rd_chk(32'h0008_0000, '1, "R8 edge beats clear");
    @(negedge clk); prog_pin_n[3] = 1'b1;
    idle(4);
    wr(32'h0008_0000);

    // R9: latch on pin 0 (bit 16), then switch to level mode with pin high
    @(negedge clk); prog_pin_n[0] = 1'b0;
    idle(4);
    @(negedge clk); prog_pin_n[0] = 1'b1;
    idle(4);
    rd_chk(32'h0001_0000, '1, "R9 latched before switch");
    @(negedge clk); edge_mode[0] = 1'b0;
    idle(3);
    rd_chk(32'h0, '1, "R9 switch drops latch");

    // R11: read data holds without a read strobe
    @(negedge clk); live_req = 19'h00123;
    rd_chk(32'h0000_0123, '1, "R11 load on read");
    @(negedge clk); live_req = 19'h70000;
    idle(4);
    direct_chk(32'h0000_0123, "R11 hold without read");

    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule